// File: doc/BRIEF.md
# Stored-Grant Switch Allocator with Crossbar

This block is the allocation and traversal core of a small wormhole router with four input ports and four output ports. Each input has a flit FIFO. When a packet's first flit reaches the front of its FIFO, its destination selects an output port and the flit bids in that output's round-robin arbiter. The winning grant is registered, and the flit crosses the crossbar in the following cycle. The register sits on the control path only; the flit itself is read straight from the FIFO front into the crossbar.

Once the first flit has crossed, its grant is kept in a per-input holding register. The output is marked as owned. The remaining flits of the packet cross using the held grant and never bid again, so a packet streams at one flit per cycle. A multiplexer picks the freshly registered grant for a first flit and the held grant for any later flit. The last flit of a packet frees both the holding register and the output. A single-flit packet claims and frees the output in one pass.

Each output keeps a downstream credit counter. A flit moves only when its output has a credit. Each input returns an upstream credit pulse for every flit that leaves its FIFO.

Top module: `sa_router`

## Requirements
- R1: After synchronous reset, every out_valid and in_credit_ret bit is 0, and each output holds CREDITS downstream credits, so CREDITS flits can leave it before any credit returns.
- R2: A flit whose type field (bits 11:10) is head (2'b01) or head-tail (2'b11) selects the output whose index equals its destination field (bits 9:8). If the FIFO was empty, the output is free and a credit is available, the flit appears on that output on the second clock edge after the edge that captured it. It arrives with all 12 bits unchanged.
- R3: Body (2'b00) and tail (2'b10) flits that follow a granted head leave through the same output with no further arbitration, at one flit per cycle, with no flit of another packet between them.
- R4: From the cycle its head is granted until its tail has crossed, an output carries only that packet. A head from another input waits, and the waiting head appears on the second edge after the edge that sent the tail, leaving exactly one idle cycle.
- R5: When several heads bid for one free output, the arbiter grants in round-robin order. After input w wins, the next grant goes to the first bidder after w in cyclic index order.
- R6: A flit crosses only if its output's credit count is non-zero. Each crossing consumes a credit, and each credit_in pulse adds one. A flit stalled at zero credits appears on the edge after the edge that captured the credit pulse.
- R7: A head-tail flit claims its output and frees it in one pass, so a later head to the same output again sees the latency of R2.
- R8: in_credit_ret[i] pulses for one cycle on the same edge that input i's flit appears on its output.
- R9: Outputs are independent. Packets from different inputs to different outputs cross in the same cycle, and at most one input drives any output in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Flit present on the matching input lane |
| in_flit | input | 48 | Four 12-bit flits, lane i at bits 12*i+11:12*i |
| in_credit_ret | output | 4 | Per-input upstream credit pulse, one per flit sent |
| out_valid | output | 4 | Registered flit valid per output |
| out_flit | output | 48 | Four registered 12-bit output flits, lane o at bits 12*o+11:12*o |
| credit_in | input | 4 | Per-output downstream credit return pulse |

## Verification
Counting from the edge that captures a head flit, the head is due on its output two edges later. Its followers are due on the edges directly after it. A head queued behind another packet is due two edges after that packet's tail. A flit stalled for credit is due one edge after the edge that captures the credit pulse. The upstream credit pulse is due on the same edge as the flit's output. A monitor stamps every output flit and every credit pulse with the index of the clock edge that produced it, sampling half a nanosecond after that edge. Each check compares those stamps and flit values against edge numbers that the bench computes from the cycle in which it drove the stimulus.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;
    parameter int NP     = 4;
    parameter int DEST_W = (NP > 1) ? $clog2(NP) : 1;
    parameter int DATA_W = 8;
    parameter int FLIT_W = 2 + DEST_W + DATA_W;

    // bit 0 = opens a packet, bit 1 = closes a packet
    typedef enum logic [1:0] {
        FT_BODY = 2'b00,
        FT_HEAD = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } ftype_e;

    typedef struct packed {
        ftype_e              ftype;
        logic [DEST_W-1:0]   dest;
        logic [DATA_W-1:0]   data;
    } flit_t;

    typedef struct packed {
        logic              vld;
        logic [DEST_W-1:0] port;
    } route_t;

    function automatic logic opens(input ftype_e t);
        return t[0];
    endfunction

    function automatic logic closes(input ftype_e t);
        return t[1];
    endfunction

    // fixed destination-to-output mapping
    function automatic logic [DEST_W-1:0] route_of(input logic [DEST_W-1:0] d);
        return d;
    endfunction
endpackage

// File: rtl/sa_fifo.sv
`timescale 1ns/1ps
module sa_fifo
    import sa_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t din,
    input  logic  pop,
    output flit_t dout,
    output logic  valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    flit_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           push_ok;

    assign push_ok = push && (cnt != CW'(DEPTH));
    assign dout    = mem[rp];
    assign valid   = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) begin
                mem[wp] <= din;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (pop && valid) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            case ({push_ok, pop && valid})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // upstream must respect the credit pulses it receives
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CW'(DEPTH)));
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);
endmodule

// File: rtl/sa_rr_arb.sv
`timescale 1ns/1ps
module sa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    int            win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = 0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = idx;
                found    = 1'b1;
            end
        end
    end

    // priority moves past the winner only when a grant is issued
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= PW'((win + 1) % N);
        end
    end

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_grant_requested_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/sa_credit.sv
`timescale 1ns/1ps
module sa_credit #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic spend,
    input  logic refill,
    output logic avail
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt;

    assign avail = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(MAX);
        end else begin
            case ({spend, refill})
                2'b10:   cnt <= cnt - CW'(1);
                2'b01:   cnt <= cnt + CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_spend_needs_credit_R6: assert property (@(posedge clk) disable iff (rst)
        spend |-> avail);
    assert_credit_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAX));
endmodule

// File: rtl/sa_router.sv
`timescale 1ns/1ps
module sa_router
    import sa_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CREDITS    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        in_valid,
    input  logic [NP*FLIT_W-1:0] in_flit,
    output logic [NP-1:0]        in_credit_ret,
    output logic [NP-1:0]        out_valid,
    output logic [NP*FLIT_W-1:0] out_flit,
    input  logic [NP-1:0]        credit_in
);
    localparam int PW = DEST_W;

    flit_t           front   [NP];
    logic [NP-1:0]   fvld;
    logic [NP-1:0]   send;
    route_t          gnt_q   [NP];   // registered new grant, waiting for its head
    route_t          held    [NP];   // stored grant for body/tail flits
    route_t          sel     [NP];   // control-path grant select
    logic [NP-1:0]   gin_v;
    logic [PW-1:0]   gin_p   [NP];
    logic [NP-1:0]   own_v;
    logic [NP-1:0]   cred_ok;
    logic [NP-1:0]   spend;
    logic [NP-1:0]   tail_out;
    logic [NP-1:0]   req_m   [NP];   // indexed by output, bit per input
    logic [NP-1:0]   gnt_m   [NP];
    logic [NP-1:0]   snd_m   [NP];
    flit_t           xbar    [NP];
    flit_t           out_f   [NP];
    logic [NP-1:0]   out_v;
    logic [NP-1:0]   cr_ret;

    // input buffers
    for (genvar i = 0; i < NP; i++) begin : g_in
        sa_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (in_valid[i]),
            .din   (flit_t'(in_flit[i*FLIT_W +: FLIT_W])),
            .pop   (send[i]),
            .dout  (front[i]),
            .valid (fvld[i])
        );
    end

    // per-output arbiter and downstream credit counter
    for (genvar o = 0; o < NP; o++) begin : g_out
        sa_rr_arb #(.N(NP)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req_m[o]),
            .gnt (gnt_m[o])
        );
        sa_credit #(.MAX(CREDITS)) u_cred (
            .clk    (clk),
            .rst    (rst),
            .spend  (spend[o]),
            .refill (credit_in[o]),
            .avail  (cred_ok[o])
        );
        assign out_flit[o*FLIT_W +: FLIT_W] = out_f[o];
    end

    // route computation and allocation requests: heads only
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            req_m[o] = '0;
            for (int i = 0; i < NP; i++) begin
                req_m[o][i] = fvld[i] && opens(front[i].ftype)
                              && !gnt_q[i].vld && !held[i].vld && !own_v[o]
                              && (route_of(front[i].dest) == PW'(o));
            end
        end
    end

    // collect each input's fresh grant
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            gin_v[i] = 1'b0;
            gin_p[i] = '0;
            for (int o = 0; o < NP; o++) begin
                if (gnt_m[o][i]) begin
                    gin_v[i] = 1'b1;
                    gin_p[i] = PW'(o);
                end
            end
        end
    end

    // grant select mux and traversal condition
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            sel[i]  = opens(front[i].ftype) ? gnt_q[i] : held[i];
            send[i] = fvld[i] && sel[i].vld && cred_ok[sel[i].port];
        end
    end

    // crossbar
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            snd_m[o]    = '0;
            xbar[o]     = '0;
            tail_out[o] = 1'b0;
            for (int i = 0; i < NP; i++) begin
                if (send[i] && (sel[i].port == PW'(o))) begin
                    snd_m[o][i] = 1'b1;
                    xbar[o]     = front[i];
                    tail_out[o] = closes(front[i].ftype);
                end
            end
            spend[o] = |snd_m[o];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) begin
                gnt_q[i] <= '0;
                held[i]  <= '0;
            end
            for (int o = 0; o < NP; o++) begin
                out_f[o] <= '0;
            end
            own_v  <= '0;
            out_v  <= '0;
            cr_ret <= '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (gin_v[i]) begin
                    gnt_q[i].vld  <= 1'b1;
                    gnt_q[i].port <= gin_p[i];
                end else if (send[i] && opens(front[i].ftype)) begin
                    gnt_q[i].vld <= 1'b0;
                end
                if (send[i]) begin
                    if (closes(front[i].ftype)) begin
                        held[i].vld <= 1'b0;
                    end else if (opens(front[i].ftype)) begin
                        held[i] <= sel[i];
                    end
                end
            end
            for (int o = 0; o < NP; o++) begin
                if (|gnt_m[o]) begin
                    own_v[o] <= 1'b1;
                end else if (spend[o] && tail_out[o]) begin
                    own_v[o] <= 1'b0;
                end
                out_f[o] <= xbar[o];
            end
            out_v  <= spend;
            cr_ret <= send;
        end
    end

    assign out_valid     = out_v;
    assign in_credit_ret = cr_ret;

    for (genvar o = 0; o < NP; o++) begin : g_chk
        assert_grant_free_output_R4: assert property (@(posedge clk) disable iff (rst)
            (|gnt_m[o]) |-> !own_v[o]);
        assert_single_sender_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(snd_m[o]));
        assert_tail_release_R7: assert property (@(posedge clk) disable iff (rst)
            (spend[o] && tail_out[o]) |=> !own_v[o]);
        assert_send_owned_R3: assert property (@(posedge clk) disable iff (rst)
            spend[o] |-> own_v[o]);
    end
endmodule

// File: tb/tb_sa_router.sv
`timescale 1ns/1ps
module tb_sa_router;
    import sa_pkg::*;

    localparam int FW = FLIT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*FW-1:0]  in_flit  = '0;
    logic [NP-1:0]     in_credit_ret;
    logic [NP-1:0]     out_valid;
    logic [NP*FW-1:0]  out_flit;
    logic [NP-1:0]     credit_in;
    logic [NP-1:0]     credit_man  = '0;
    logic [NP-1:0]     credit_auto = '0;
    logic              auto_en = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    int          log_cyc  [NP][256];
    logic [FW-1:0] log_flit [NP][256];
    int          log_n    [NP];
    int          cr_cyc   [NP][256];
    int          cr_n     [NP];

    assign credit_in = credit_auto | credit_man;

    sa_router #(.FIFO_DEPTH(4), .CREDITS(4)) dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_flit       (in_flit),
        .in_credit_ret (in_credit_ret),
        .out_valid     (out_valid),
        .out_flit      (out_flit),
        .credit_in     (credit_in)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int o = 0; o < NP; o++) begin
            log_n[o] = 0;
            cr_n[o]  = 0;
        end
    end

    // monitor: stamps outputs with edge index, returns credits when enabled
    always @(posedge clk) begin
        #0.5;
        cyc = cyc + 1;
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && log_n[o] < 256) begin
                log_cyc[o][log_n[o]]  = cyc;
                log_flit[o][log_n[o]] = out_flit[o*FW +: FW];
                log_n[o] = log_n[o] + 1;
            end
            if (in_credit_ret[o] && cr_n[o] < 256) begin
                cr_cyc[o][cr_n[o]] = cyc;
                cr_n[o] = cr_n[o] + 1;
            end
        end
        credit_auto = auto_en ? out_valid : '0;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input logic [1:0] ft, input int dst,
                                         input int inp, input int idx);
        return {ft, DEST_W'(dst), 2'(inp), 2'b00, 4'(idx)};
    endfunction

    task automatic put(input int i, input logic [FW-1:0] f);
        in_valid[i] = 1'b1;
        in_flit[i*FW +: FW] = f;
    endtask

    task automatic clr();
        in_valid = '0;
        in_flit  = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int s, b, b2, p;
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1: idle outputs after reset
        chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
        chk(in_credit_ret == '0, "R1 credit_ret", int'(in_credit_ret), 0);

        // R2/R7/R8: every input to every output with a single-flit packet
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                logic [FW-1:0] f;
                f = mk(2'b11, o, i, o);
                s = cyc;
                put(i, f);
                tick();
                clr();
                tick();
                tick();
                chk(out_valid == NP'(1 << o), "R2 out_valid", int'(out_valid), 1 << o);
                chk(out_flit[o*FW +: FW] == f, "R7 flit", int'(out_flit[o*FW +: FW]), int'(f));
                chk(in_credit_ret == NP'(1 << i), "R8 credit_ret", int'(in_credit_ret), 1 << i);
                chk(cyc == s + 3, "R2 latency", cyc, s + 3);
                tick();
            end
        end

        // R3: four-flit packets stream back to back
        for (int i = 0; i < NP; i++) begin
            int o;
            o = (i + 1) % NP;
            b = log_n[o];
            s = cyc;
            for (int k = 0; k < 4; k++) begin
                put(i, mk((k == 0) ? 2'b01 : ((k == 3) ? 2'b10 : 2'b00), o, i, k));
                tick();
            end
            clr();
            repeat (6) tick();
            chk(log_n[o] == b + 4, "R3 count", log_n[o] - b, 4);
            for (int k = 0; k < 4; k++) begin
                chk(log_cyc[o][b + k] == s + 3 + k, "R3 timing", log_cyc[o][b + k], s + 3 + k);
                chk(log_flit[o][b + k][3:0] == 4'(k) && log_flit[o][b + k][7:6] == 2'(i),
                    "R3 order", int'(log_flit[o][b + k]), k);
            end
        end

        // R4/R5: all inputs contend for output 2 with two-flit packets
        b = log_n[2];
        s = cyc;
        for (int i = 0; i < NP; i++) put(i, mk(2'b01, 2, i, 0));
        tick();
        for (int i = 0; i < NP; i++) put(i, mk(2'b10, 2, i, 1));
        tick();
        clr();
        repeat (20) tick();
        chk(log_n[2] == b + 8, "R4 count", log_n[2] - b, 8);
        chk(log_cyc[2][b] == s + 3, "R2 first head", log_cyc[2][b], s + 3);
        for (int k = 0; k < 4; k++) begin
            logic [FW-1:0] h, t;
            h = log_flit[2][b + 2*k];
            t = log_flit[2][b + 2*k + 1];
            chk(h[11:10] == 2'b01 && t[11:10] == 2'b10 && h[7:6] == t[7:6],
                "R4 packet intact", int'(t), int'(h));
            chk(log_cyc[2][b + 2*k + 1] == log_cyc[2][b + 2*k] + 1, "R3 tail follows",
                log_cyc[2][b + 2*k + 1], log_cyc[2][b + 2*k] + 1);
            if (k > 0) begin
                logic [FW-1:0] pv;
                pv = log_flit[2][b + 2*k - 2];
                chk(log_cyc[2][b + 2*k] == log_cyc[2][b + 2*k - 1] + 2, "R4 idle gap",
                    log_cyc[2][b + 2*k], log_cyc[2][b + 2*k - 1] + 2);
                chk(h[7:6] == 2'(pv[7:6] + 2'd1), "R5 rotation", int'(h[7:6]),
                    int'(2'(pv[7:6] + 2'd1)));
            end
        end

        // R1/R6: credits run out and return
        repeat (4) tick();
        auto_en = 1'b0;
        b = log_n[3];
        s = cyc;
        for (int k = 0; k < 4; k++) begin
            put(1, mk((k == 0) ? 2'b01 : ((k == 3) ? 2'b10 : 2'b00), 3, 1, k));
            tick();
        end
        clr();
        repeat (6) tick();
        chk(log_n[3] == b + 4, "R1 initial credits", log_n[3] - b, 4);
        chk(log_cyc[3][b + 3] == s + 6, "R6 last credit", log_cyc[3][b + 3], s + 6);
        b2 = log_n[3];
        put(0, mk(2'b11, 3, 0, 9));
        tick();
        clr();
        repeat (8) tick();
        chk(log_n[3] == b2, "R6 stall at zero", log_n[3] - b2, 0);
        p = cyc;
        credit_man[3] = 1'b1;
        tick();
        credit_man[3] = 1'b0;
        tick();
        chk(log_n[3] == b2 + 1, "R6 release count", log_n[3] - b2, 1);
        chk(log_cyc[3][b2] == p + 2, "R6 release timing", log_cyc[3][b2], p + 2);
        chk(cr_cyc[0][cr_n[0] - 1] == p + 2, "R8 stalled credit_ret", cr_cyc[0][cr_n[0] - 1], p + 2);
        credit_man[3] = 1'b1;
        repeat (4) tick();
        credit_man[3] = 1'b0;
        auto_en = 1'b1;
        repeat (3) tick();

        // R9: four disjoint pairs cross together
        s = cyc;
        put(0, mk(2'b11, 1, 0, 5));
        put(1, mk(2'b11, 0, 1, 5));
        put(2, mk(2'b11, 3, 2, 5));
        put(3, mk(2'b11, 2, 3, 5));
        tick();
        clr();
        tick();
        tick();
        chk(out_valid == '1, "R9 parallel", int'(out_valid), 15);
        chk(in_credit_ret == '1, "R8 parallel credit_ret", int'(in_credit_ret), 15);
        chk(out_flit[2*FW +: FW] == mk(2'b11, 2, 3, 5), "R9 flit lane2",
            int'(out_flit[2*FW +: FW]), int'(mk(2'b11, 2, 3, 5)));
        tick();
        chk(out_valid == '0, "R9 single beat", int'(out_valid), 0);

        repeat (4) tick();
        finish_run();
    end
endmodule